// File: doc/BRIEF.md
# Small Multicycle 16-bit Register Processor

This block is a compact processor core that executes fixed-width 16-bit instruction words. Each instruction passes through four steps: fetch, decode, execute and write-back. It works on eight 16-bit general registers and on a 128-word data memory that sits inside the core. Arithmetic uses two operands and overwrites its first operand: the destination register is also the left-hand operand. Loads and stores name a 7-bit absolute word address. A single conditional branch jumps relative to the next instruction when two registers hold the same value.

Program memory is filled through a write port, and only while reset is held. After reset is released the core runs from address 0 until it meets a HALT word. It then parks and raises its `halted` output. Any register can be read at any time through a combinational peek port, and the current program counter is visible on its own output.

Top module: `mc_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the PC to 0, deasserts `halted`, and zeroes all eight registers and all 128 data-memory words.
- R2: Every instruction is one 16-bit word with its opcode in bits [15:12]. A non-halting instruction takes exactly four clock cycles. The PC output changes only on the fourth edge after the instruction is fetched, and it steps by one unless the instruction is a taken branch or a jump.
- R3: Opcode 1 (ADD) sets reg[ir[8:6]] = reg[ir[8:6]] + reg[ir[11:9]], modulo 2^16.
- R4: Opcode 2 (SUB) sets reg[ir[8:6]] = reg[ir[8:6]] - reg[ir[11:9]], modulo 2^16.
- R5: Opcode 3 (ADDI) adds the two's-complement 6-bit field ir[5:0] (range -32..31), sign-extended to 16 bits, to reg[ir[8:6]] and stores the sum there.
- R6: Opcode 5 (ST) writes reg[ir[11:9]] to data word ir[6:0]. Opcode 4 (LD) copies data word ir[6:0] into reg[ir[11:9]]. Addresses 0 and 127 are both reachable.
- R7: Opcode 6 (BEQ) compares reg[ir[11:9]] with reg[ir[8:6]]. If they are equal, the PC becomes PC + 1 + sign-extended ir[5:0], taken modulo 128. Otherwise the PC becomes PC + 1.
- R8: Opcode 7 (JMP) loads the PC with ir[6:0]. The instructions it skips have no effect.
- R9: Opcode 0 (NOP) and every unassigned opcode (8 to 14) change no register or memory word; they only advance the PC.
- R10: Opcode 15 (HALT) raises `halted` three edges after its fetch edge. The PC then stays at the HALT's address until the next reset.
- R11: A register changes only on the write-back edge, which is the fourth edge of its instruction. Before that edge the peek port still returns the old value.
- R12: Program-memory writes are accepted only while `rst` is high. A write presented after reset is released is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables program loading |
| imem_we | input | 1 | Program-memory write strobe |
| imem_waddr | input | 7 | Program-memory write address |
| imem_wdata | input | 16 | Program word to write |
| peek_sel | input | 3 | Register number to observe |
| peek_data | output | DATA_W | Current content of the selected register |
| pc | output | 7 | Program counter |
| halted | output | 1 | High once a HALT has executed, until reset |

## Verification
The bench builds the core with its default 16-bit data width. With that width, the results of arithmetic that wraps around (for example 0xFFFF + 0xFFFF) can be compared exactly against a bit-true software model. The 7-bit address space is used in full, so the bench can reach the top data word (127), place code at addresses above 100, and take a backward branch that wraps below address 0 to land at 123. Each directed program is executed by the model as well as by the core. After HALT, every register and the final PC are compared, and memory contents are read back through LD instructions.

// File: rtl/mc_pkg.sv
package mc_pkg;
   localparam int INSTR_W = 16;
   localparam int PC_W    = 7;
   localparam int RSEL_W  = 3;
   localparam int IMM_W   = 6;
   localparam int NREG    = 1 << RSEL_W;

   localparam logic [3:0] OP_NOP  = 4'd0;
   localparam logic [3:0] OP_ADD  = 4'd1;
   localparam logic [3:0] OP_SUB  = 4'd2;
   localparam logic [3:0] OP_ADDI = 4'd3;
   localparam logic [3:0] OP_LD   = 4'd4;
   localparam logic [3:0] OP_ST   = 4'd5;
   localparam logic [3:0] OP_BEQ  = 4'd6;
   localparam logic [3:0] OP_JMP  = 4'd7;
   localparam logic [3:0] OP_HALT = 4'd15;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_DECODE,
      ST_EXEC,
      ST_WB,
      ST_PARK
   } state_e;
endpackage

// File: rtl/mc_ram.sv
module mc_ram #(
   parameter int DW    = 16,
   parameter int AW    = 7,
   parameter bit CLEAR = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   initial begin
      assert (DW > 0 && AW > 0) else $error("mc_ram: bad geometry");
   end

   generate
      if (CLEAR) begin : g_clear
         // reset wipes the array; writes land only in normal operation
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_preload
         // contents kept across reset; writes accepted only while reset held
         always_ff @(posedge clk) begin
            if (we && rst) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int DW = 16,
   parameter int SW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [SW-1:0] wsel,
   input  logic [DW-1:0] wdata,
   input  logic [SW-1:0] rsel_a,
   output logic [DW-1:0] rdata_a,
   input  logic [SW-1:0] rsel_b,
   output logic [DW-1:0] rdata_b,
   input  logic [SW-1:0] psel,
   output logic [DW-1:0] pdata
);
   localparam int N = 1 << SW;

   logic [DW-1:0] regs [N];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) regs[i] <= '0;
      end else if (we) begin
         regs[wsel] <= wdata;
      end
   end

   assign rdata_a = regs[rsel_a];
   assign rdata_b = regs[rsel_b];
   assign pdata   = regs[psel];
endmodule

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; #(
   parameter int DW = 16,
   parameter int IW = 6
) (
   input  logic [3:0]    op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [IW-1:0] imm,
   output logic [DW-1:0] y,
   output logic          eq
);
   localparam int EXT = DW - IW;

   logic [DW-1:0] imm_x;

   assign imm_x = {{EXT{imm[IW-1]}}, imm};
   assign eq    = (a == b);

   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_ADDI: y = a + imm_x;
         default: y = b;
      endcase
   end
endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              imem_we,
   input  logic [PC_W-1:0]   imem_waddr,
   input  logic [INSTR_W-1:0] imem_wdata,
   input  logic [RSEL_W-1:0] peek_sel,
   output logic [DATA_W-1:0] peek_data,
   output logic [PC_W-1:0]   pc,
   output logic              halted
);
   initial begin
      assert (DATA_W > IMM_W + 1) else $error("mc_core: DATA_W too narrow for immediate");
   end

   state_e              state;
   logic [PC_W-1:0]     pc_q, pc_next, br_tgt;
   logic [INSTR_W-1:0]  ir, imem_rd;
   logic [DATA_W-1:0]   opa, opb, res, rd_a, rd_b, alu_y, dmem_rd;
   logic                taken, halted_q, alu_eq;
   logic [3:0]          op;
   logic [RSEL_W-1:0]   f_hi, f_mid, wsel;
   logic                rf_we, dmem_we, wr_class;

   assign op    = ir[15:12];
   assign f_hi  = ir[11:9];
   assign f_mid = ir[8:6];

   mc_ram #(.DW(INSTR_W), .AW(PC_W), .CLEAR(1'b0)) u_imem (
      .clk(clk), .rst(rst), .we(imem_we), .waddr(imem_waddr),
      .wdata(imem_wdata), .raddr(pc_q), .rdata(imem_rd));

   mc_ram #(.DW(DATA_W), .AW(PC_W), .CLEAR(1'b1)) u_dmem (
      .clk(clk), .rst(rst), .we(dmem_we), .waddr(ir[PC_W-1:0]),
      .wdata(opb), .raddr(ir[PC_W-1:0]), .rdata(dmem_rd));

   mc_regfile #(.DW(DATA_W), .SW(RSEL_W)) u_rf (
      .clk(clk), .rst(rst), .we(rf_we), .wsel(wsel), .wdata(res),
      .rsel_a(f_mid), .rdata_a(rd_a), .rsel_b(f_hi), .rdata_b(rd_b),
      .psel(peek_sel), .pdata(peek_data));

   mc_alu #(.DW(DATA_W), .IW(IMM_W)) u_alu (
      .op(op), .a(opa), .b(opb), .imm(ir[IMM_W-1:0]), .y(alu_y), .eq(alu_eq));

   assign wr_class = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI) || (op == OP_LD);
   assign rf_we    = (state == ST_WB) && wr_class;
   assign wsel     = (op == OP_LD) ? f_hi : f_mid;
   assign dmem_we  = (state == ST_EXEC) && (op == OP_ST);

   assign br_tgt = pc_q + 1'b1 + {ir[IMM_W-1], ir[IMM_W-1:0]};

   always_comb begin
      if (op == OP_JMP)  pc_next = ir[PC_W-1:0];
      else if (taken)    pc_next = br_tgt;
      else               pc_next = pc_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_FETCH;
         pc_q     <= '0;
         ir       <= '0;
         opa      <= '0;
         opb      <= '0;
         res      <= '0;
         taken    <= 1'b0;
         halted_q <= 1'b0;
      end else begin
         case (state)
            ST_FETCH: begin
               ir    <= imem_rd;
               state <= ST_DECODE;
            end
            ST_DECODE: begin
               opa   <= rd_a;
               opb   <= rd_b;
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               if (op == OP_HALT) begin
                  halted_q <= 1'b1;
                  state    <= ST_PARK;
               end else begin
                  res   <= (op == OP_LD) ? dmem_rd : alu_y;
                  taken <= (op == OP_BEQ) && alu_eq;
                  state <= ST_WB;
               end
            end
            ST_WB: begin
               pc_q  <= pc_next;
               state <= ST_FETCH;
            end
            default: state <= ST_PARK;
         endcase
      end
   end

   assign pc     = pc_q;
   assign halted = halted_q;

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted); // R10
   AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (rst) halted |=> $stable(pc)); // R10
   AST_PC_ONLY_AT_WB: assert property (@(posedge clk) disable iff (rst) (state != ST_WB) |=> $stable(pc)); // R2
   AST_REG_ONLY_AT_WB: assert property (@(posedge clk) disable iff (rst) (state != ST_WB) |=> $stable(peek_data) || !$stable(peek_sel)); // R11
   AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst) (state == ST_FETCH) |=> (state == ST_DECODE)); // R2
   AST_DECODE_TO_EXEC: assert property (@(posedge clk) disable iff (rst) (state == ST_DECODE) |=> (state == ST_EXEC)); // R2
endmodule

// File: tb/mc_core_tb.sv
module mc_core_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        imem_we = 1'b0;
   logic [6:0]  imem_waddr = '0;
   logic [15:0] imem_wdata = '0;
   logic [2:0]  peek_sel = '0;
   logic [15:0] peek_data;
   logic [6:0]  pc;
   logic        halted;

   int n_chk = 0;
   int n_fail = 0;

   logic [15:0] prog [128];
   logic [15:0] mreg [8];
   logic [15:0] mmem [128];
   logic [6:0]  mpc;

   always #5 clk = ~clk;

   mc_core #(.DATA_W(16)) u_dut (
      .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
      .imem_wdata(imem_wdata), .peek_sel(peek_sel), .peek_data(peek_data),
      .pc(pc), .halted(halted));

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] enc_r(input logic [3:0] op, input int src, input int dst);
      return {op, 3'(src), 3'(dst), 6'd0};
   endfunction
   function automatic logic [15:0] enc_i(input int dst, input int imm);
      return {4'd3, 3'd0, 3'(dst), 6'(imm)};
   endfunction
   function automatic logic [15:0] enc_m(input logic [3:0] op, input int r, input int addr);
      return {op, 3'(r), 2'd0, 7'(addr)};
   endfunction
   function automatic logic [15:0] enc_b(input int ra, input int rb, input int off);
      return {4'd6, 3'(ra), 3'(rb), 6'(off)};
   endfunction
   function automatic logic [15:0] enc_j(input int tgt);
      return {4'd7, 5'd0, 7'(tgt)};
   endfunction

   task automatic clear_prog();
      for (int i = 0; i < 128; i++) prog[i] = 16'hF000;
   endtask

   // software model of the instruction semantics
   task automatic model_run();
      logic [15:0] w;
      logic [2:0] hi, mid;
      for (int i = 0; i < 8; i++) mreg[i] = '0;
      for (int i = 0; i < 128; i++) mmem[i] = '0;
      mpc = '0;
      for (int s = 0; s < 2000; s++) begin
         w = prog[mpc];
         hi = w[11:9];
         mid = w[8:6];
         if (w[15:12] == 4'd15) break;
         case (w[15:12])
            4'd1: mreg[mid] = mreg[mid] + mreg[hi];
            4'd2: mreg[mid] = mreg[mid] - mreg[hi];
            4'd3: mreg[mid] = mreg[mid] + {{10{w[5]}}, w[5:0]};
            4'd4: mreg[hi] = mmem[w[6:0]];
            4'd5: mmem[w[6:0]] = mreg[hi];
            default: ;
         endcase
         if (w[15:12] == 4'd7) mpc = w[6:0];
         else if (w[15:12] == 4'd6 && mreg[hi] == mreg[mid]) mpc = mpc + 7'd1 + {w[5], w[5:0]};
         else mpc = mpc + 7'd1;
      end
   endtask

   task automatic load_and_release();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 128; i++) begin
         imem_we = 1'b1; imem_waddr = 7'(i); imem_wdata = prog[i];
         @(negedge clk);
      end
      imem_we = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic run_to_halt();
      for (int c = 0; c < 4000; c++) begin
         if (halted) break;
         @(negedge clk);
      end
   endtask

   task automatic compare_model(input string req);
      model_run();
      check(halted === 1'b1, req, 32'(halted), 32'd1);
      check(pc === mpc, req, 32'(pc), 32'(mpc));
      for (int r = 0; r < 8; r++) begin
         peek_sel = 3'(r);
         #1;
         check(peek_data === mreg[r], req, 32'(peek_data), 32'(mreg[r]));
      end
   endtask

   task automatic peek_check(input int r, input logic [15:0] exp, input string req);
      peek_sel = 3'(r);
      #1;
      check(peek_data === exp, req, 32'(peek_data), 32'(exp));
   endtask

   // R2 R11 R12 R10: cadence, write-back timing, preload gating, parking
   task automatic test_timing();
      clear_prog();
      prog[0] = enc_i(1, 5);
      prog[1] = 16'h0000;
      prog[2] = 16'h0000;
      prog[3] = 16'hF000;
      load_and_release();
      // late write, must be ignored (R12)
      imem_we = 1'b1; imem_waddr = 7'd1; imem_wdata = 16'hF000;
      repeat (3) @(negedge clk);
      imem_we = 1'b0;
      check(pc === 7'd0, "R2 pc held before write-back", 32'(pc), 32'd0);
      peek_check(1, 16'd0, "R11 reg unchanged before write-back");
      @(negedge clk);
      check(pc === 7'd1, "R2 pc steps on fourth edge", 32'(pc), 32'd1);
      peek_check(1, 16'd5, "R11 reg written on fourth edge");
      repeat (4) @(negedge clk);
      check(pc === 7'd2, "R2 second instruction four cycles", 32'(pc), 32'd2);
      run_to_halt();
      check(pc === 7'd3, "R12 late imem write ignored", 32'(pc), 32'd3);
      repeat (20) @(negedge clk);
      check(halted === 1'b1 && pc === 7'd3, "R10 halt parks pc", 32'(pc), 32'd3);
   endtask

   // R10 halt raised three edges after fetch
   task automatic test_halt_latency();
      clear_prog();
      load_and_release();
      repeat (2) @(negedge clk);
      check(halted === 1'b0, "R10 halted low before execute", 32'(halted), 32'd0);
      @(negedge clk);
      check(halted === 1'b1 && pc === 7'd0, "R10 halted after third edge", 32'(halted), 32'd1);
   endtask

   task automatic test_arith();
      clear_prog();
      prog[0] = enc_i(1, 5);
      prog[1] = enc_i(2, -3);
      prog[2] = enc_r(4'd1, 2, 1);
      prog[3] = enc_r(4'd2, 1, 3);
      prog[4] = enc_i(4, 31);
      prog[5] = enc_i(5, -32);
      prog[6] = enc_i(6, -1);
      prog[7] = enc_r(4'd1, 6, 6);
      prog[8] = 16'hF000;
      load_and_release();
      run_to_halt();
      compare_model("R3 R4 R5 arithmetic program");
      peek_check(1, 16'h0002, "R3 add 5 + -3");
      peek_check(3, 16'hFFFE, "R4 subtract 0 - 2");
      peek_check(4, 16'h001F, "R5 immediate max 31");
      peek_check(5, 16'hFFE0, "R5 immediate min -32");
      peek_check(6, 16'hFFFE, "R3 add wraps modulo 2^16");
   endtask

   task automatic test_mem();
      clear_prog();
      prog[0] = enc_i(1, 7);
      prog[1] = enc_i(1, -20);
      prog[2] = enc_m(4'd5, 1, 127);
      prog[3] = enc_m(4'd5, 1, 5);
      prog[4] = enc_m(4'd4, 2, 127);
      prog[5] = enc_m(4'd4, 3, 6);
      prog[6] = enc_m(4'd4, 4, 5);
      prog[7] = enc_m(4'd5, 3, 0);
      prog[8] = enc_m(4'd4, 5, 0);
      prog[9] = 16'hF000;
      load_and_release();
      run_to_halt();
      compare_model("R6 load/store program");
      peek_check(2, 16'hFFF3, "R6 load from word 127");
      peek_check(3, 16'h0000, "R6 unwritten word reads zero");
      peek_check(5, 16'h0000, "R6 word 0 store and load");
   endtask

   task automatic test_reset();
      clear_prog();
      prog[0] = enc_m(4'd4, 5, 127);
      prog[1] = 16'hF000;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(pc === 7'd0 && halted === 1'b0, "R1 reset pc and halted", {24'd0, halted, pc}, 32'd0);
      for (int r = 0; r < 8; r++) peek_check(r, 16'd0, "R1 reset clears registers");
      load_and_release();
      run_to_halt();
      peek_check(5, 16'd0, "R1 reset clears data memory");
   endtask

   task automatic test_branch();
      clear_prog();
      prog[0] = enc_i(1, 4);
      prog[1] = enc_i(2, 4);
      prog[2] = enc_b(1, 2, 1);
      prog[3] = enc_i(3, 1);
      prog[4] = enc_i(2, 1);
      prog[5] = enc_b(1, 2, 3);
      prog[6] = enc_b(0, 0, -12);
      prog[123] = enc_i(7, 9);
      prog[124] = 16'hF000;
      load_and_release();
      run_to_halt();
      compare_model("R7 branch program");
      peek_check(3, 16'd0, "R7 taken branch skips instruction");
      peek_check(7, 16'd9, "R7 backward branch wraps to 123");
      check(pc === 7'd124, "R7 final pc after wrap", 32'(pc), 32'd124);
   endtask

   task automatic test_jump();
      clear_prog();
      prog[0] = enc_j(100);
      prog[1] = enc_i(1, 1);
      prog[100] = 16'hA1C5;
      prog[101] = 16'h0FFF;
      prog[102] = enc_i(2, -1);
      prog[103] = 16'hF000;
      load_and_release();
      run_to_halt();
      compare_model("R8 R9 jump and no-op program");
      peek_check(1, 16'd0, "R8 skipped instruction not run");
      peek_check(7, 16'd0, "R9 unassigned opcode writes nothing");
      peek_check(2, 16'hFFFF, "R9 execution continues after no-ops");
      check(pc === 7'd103, "R8 jump target reached", 32'(pc), 32'd103);
   endtask

   initial begin
      test_timing();
      test_halt_latency();
      test_arith();
      test_mem();
      test_reset();
      test_branch();
      test_jump();
      summary();
      $finish;
   end
endmodule